// File: doc/BRIEF.md
# Execute-Stage Fault Capture Unit

This unit sits next to the execute stage of a small 32-bit scalar core that uses a branch delay slot. Each cycle it looks at the instruction in execute: its PC, whether it occupies a delay slot, and its memory access (size, direction, effective address). It also sees the fault strobes raised elsewhere in execute: signed add/subtract overflow, a syscall, and a coprocessor instruction together with the privilege and enable bits that govern it.

When a fault is found, the unit acts in two stages. In the same cycle it cancels the memory access and blocks the register writeback, including the delayed-load destination. At the next clock edge it records the exception PC, the cause code, the delay-slot flag and, for alignment faults only, the faulting address. It also raises a one-cycle redirect pulse so that the front end can change course.

If several faults are requested in one cycle, a fixed priority picks exactly one of them. Word-merge accesses (the left/right partial-word loads and stores) work on the word that contains the address, so they are never checked for alignment.

Top module: `exc_capture_unit`

## Requirements
- R1: After reset, `epc_q`, `cause_code_q`, `cause_bd_q`, `badvaddr_q` and `redirect` are all zero.
- R2: A byte access (`mem_size`=0) never causes an alignment fault, whatever the address.
- R3: A halfword access (`mem_size`=1) faults when address bit 0 is 1. A word access (`mem_size`=2) faults when address bits 1:0 are not 00.
- R4: When `mem_word_merge` is 1, no alignment fault is raised, whatever the address and size.
- R5: A misaligned load records cause code 4. A misaligned store (`mem_write`=1) records cause code 5.
- R6: On a recorded alignment fault, `badvaddr_q` takes the full effective address. Every other fault, and every cycle without a fault, leaves `badvaddr_q` unchanged.
- R7: On a recorded fault, `epc_q` takes `ex_pc`, or `ex_pc`-4 when `ex_in_delay_slot` is 1, and `cause_bd_q` takes `ex_in_delay_slot`.
- R8: In any cycle with `ex_valid`=1 and a fault, `mem_kill` and `wb_kill` are 1 in that same cycle. Otherwise both are 0.
- R9: An overflow strobe records cause code 12. A syscall strobe records cause code 8.
- R10: A coprocessor instruction records cause code 11 when `cop_num` is not 0, or when `cop_num`=0 with `user_mode`=1 and `cu0_en`=0. Any other coprocessor instruction does not fault.
- R11: When several faults occur together, exactly one is recorded. The order of priority is coprocessor-unusable, then syscall, then overflow, then alignment.
- R12: `redirect` is 1 for exactly the cycle that follows each faulting cycle. The capture registers are unchanged after a cycle without a fault.
- R13: With `ex_valid`=0, no fault strobe or address has any effect: kills stay low and nothing is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | A real instruction is in execute |
| ex_pc | input | 32 | PC of the instruction in execute |
| ex_in_delay_slot | input | 1 | That instruction sits in a branch delay slot |
| mem_req | input | 1 | Instruction performs a load or store |
| mem_write | input | 1 | 1 = store, 0 = load |
| mem_size | input | 2 | 0 byte, 1 halfword, 2 word |
| mem_word_merge | input | 1 | Left/right word-merge access (address low bits ignored) |
| mem_addr | input | 32 | Effective virtual address |
| ovf_req | input | 1 | Signed add/subtract overflowed |
| syscall_req | input | 1 | Syscall instruction |
| cop_req | input | 1 | Coprocessor instruction |
| cop_num | input | 2 | Coprocessor number |
| user_mode | input | 1 | Core is in user mode |
| cu0_en | input | 1 | Coprocessor 0 usable in user mode |
| mem_kill | output | 1 | Cancel this cycle's memory access |
| wb_kill | output | 1 | Block this instruction's register/delayed-load writeback |
| redirect | output | 1 | One-cycle pulse after a recorded fault |
| epc_q | output | 32 | Saved exception PC |
| cause_code_q | output | 5 | Saved cause code |
| cause_bd_q | output | 1 | Saved delay-slot flag |
| badvaddr_q | output | 32 | Saved faulting address |

## Verification
The hardest case to reach from the ports is a masked alignment fault: a misaligned address that loses arbitration to a higher-priority fault in the same cycle. From outside, the only sign of it is that `badvaddr_q` keeps its old value. The bench first records an alignment fault so that `badvaddr_q` holds a known value. It then drives overflow or syscall strobes together with a new misaligned address and checks that the code and EPC change while the saved address does not. Delay-slot EPC correction and the cases where a coprocessor-0 instruction does not fault are driven with the same directed tasks.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int unsigned CODE_W = 5;
   localparam logic [CODE_W-1:0] CODE_NONE  = 5'd0;
   localparam logic [CODE_W-1:0] CODE_ADEL  = 5'd4;
   localparam logic [CODE_W-1:0] CODE_ADES  = 5'd5;
   localparam logic [CODE_W-1:0] CODE_SYS   = 5'd8;
   localparam logic [CODE_W-1:0] CODE_COPU  = 5'd11;
   localparam logic [CODE_W-1:0] CODE_OVF   = 5'd12;

   // fault source index == priority rank (0 highest)
   typedef enum logic [1:0] {
      SRC_COPU = 2'd0,
      SRC_SYS  = 2'd1,
      SRC_OVF  = 2'd2,
      SRC_ALGN = 2'd3
   } fault_src_e;
   localparam int unsigned NUM_SRC = 4;
endpackage

// File: rtl/exc_align_check.sv
module exc_align_check #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned NSIZES = 3,
   parameter int unsigned SIZE_W = 2
) (
   input  logic [XLEN-1:0]   addr,
   input  logic [SIZE_W-1:0] size,
   input  logic              word_merge,
   output logic              misalign
);
   initial begin
      if (NSIZES < 1 || NSIZES > (1 << SIZE_W)) $error("NSIZES out of range");
      if (XLEN < (1 << (NSIZES - 1)) * 8) $error("XLEN too narrow for largest size");
   end

   logic [NSIZES-1:0] bad_by_size;

   generate
      for (genvar s = 0; s < NSIZES; s++) begin : g_size
         if (s == 0) begin : g_byte
            assign bad_by_size[s] = 1'b0;
         end else begin : g_wide
            assign bad_by_size[s] = |addr[s-1:0];
         end
      end
   endgenerate

   always_comb begin
      misalign = 1'b0;
      for (int i = 0; i < NSIZES; i++) begin
         if (size == SIZE_W'(i)) misalign = bad_by_size[i];
      end
      if (word_merge) misalign = 1'b0;
   end

   // R2: a byte access can never report misalignment
   always_comb begin
      p_byte_never_r2: assert (!(size == '0 && misalign));
   end
endmodule

// File: rtl/exc_fault_arbiter.sv
module exc_fault_arbiter
   import exc_pkg::*;
(
   input  logic [NUM_SRC-1:0] req,
   input  logic               is_store,
   output logic               fault,
   output logic [NUM_SRC-1:0] grant,
   output logic [CODE_W-1:0]  code
);
   logic [NUM_SRC-1:0] higher;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_rank
         if (i == 0) begin : g_top
            assign higher[i] = 1'b0;
         end else begin : g_low
            assign higher[i] = higher[i-1] | req[i-1];
         end
         assign grant[i] = req[i] & ~higher[i];
      end
   endgenerate

   assign fault = |req;

   always_comb begin
      code = CODE_NONE;
      unique case (1'b1)
         grant[SRC_COPU]: code = CODE_COPU;
         grant[SRC_SYS]:  code = CODE_SYS;
         grant[SRC_OVF]:  code = CODE_OVF;
         grant[SRC_ALGN]: code = is_store ? CODE_ADES : CODE_ADEL;
         default:         code = CODE_NONE;
      endcase
   end

   // R11: at most one source wins, and one wins whenever any requests
   always_comb begin
      p_one_winner_r11: assert ($onehot0(grant) && ((|grant) == fault));
   end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
   import exc_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned PC_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              take_addr,
   input  logic [XLEN-1:0]   pc,
   input  logic              in_ds,
   input  logic [CODE_W-1:0] code,
   input  logic [XLEN-1:0]   addr,
   output logic              redirect,
   output logic [XLEN-1:0]   epc_q,
   output logic [CODE_W-1:0] code_q,
   output logic              bd_q,
   output logic [XLEN-1:0]   bad_q
);
   logic [XLEN-1:0] epc_next;
   assign epc_next = in_ds ? (pc - XLEN'(PC_STEP)) : pc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q    <= '0;
         code_q   <= CODE_NONE;
         bd_q     <= 1'b0;
         bad_q    <= '0;
         redirect <= 1'b0;
      end else begin
         redirect <= take;
         if (take) begin
            epc_q  <= epc_next;
            code_q <= code;
            bd_q   <= in_ds;
         end
         if (take && take_addr) bad_q <= addr;
      end
   end

   // R12: no recorded fault, no redirect and no state change
   p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> (!redirect && $stable(epc_q) && $stable(code_q) && $stable(bd_q)));
   // R6: saved address only moves on an alignment fault
   p_bad_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(take && take_addr) |=> $stable(bad_q));
   // R7: delay-slot flag follows the faulting instruction
   p_bd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (bd_q == $past(in_ds)));
endmodule

// File: rtl/exc_capture_unit.sv
module exc_capture_unit
   import exc_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned NSIZES  = 3,
   parameter int unsigned PC_STEP = 4,
   parameter int unsigned COP_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ex_valid,
   input  logic [XLEN-1:0]   ex_pc,
   input  logic              ex_in_delay_slot,
   input  logic              mem_req,
   input  logic              mem_write,
   input  logic [1:0]        mem_size,
   input  logic              mem_word_merge,
   input  logic [XLEN-1:0]   mem_addr,
   input  logic              ovf_req,
   input  logic              syscall_req,
   input  logic              cop_req,
   input  logic [COP_W-1:0]  cop_num,
   input  logic              user_mode,
   input  logic              cu0_en,
   output logic              mem_kill,
   output logic              wb_kill,
   output logic              redirect,
   output logic [XLEN-1:0]   epc_q,
   output logic [CODE_W-1:0] cause_code_q,
   output logic              cause_bd_q,
   output logic [XLEN-1:0]   badvaddr_q
);
   localparam int unsigned SIZE_W = 2;

   initial begin
      if (PC_STEP == 0) $error("PC_STEP must be nonzero");
      if (COP_W < 1) $error("COP_W must be at least 1");
   end

   logic               misalign;
   logic               cop_unusable;
   logic [NUM_SRC-1:0] req;
   logic [NUM_SRC-1:0] grant;
   logic               any_fault;
   logic               take;
   logic [CODE_W-1:0]  code;

   exc_align_check #(
      .XLEN   (XLEN),
      .NSIZES (NSIZES),
      .SIZE_W (SIZE_W)
   ) align_i (
      .addr       (mem_addr),
      .size       (mem_size),
      .word_merge (mem_word_merge),
      .misalign   (misalign)
   );

   assign cop_unusable = cop_req && ((cop_num != '0) || (user_mode && !cu0_en));

   always_comb begin
      req           = '0;
      req[SRC_COPU] = cop_unusable;
      req[SRC_SYS]  = syscall_req;
      req[SRC_OVF]  = ovf_req;
      req[SRC_ALGN] = mem_req && misalign;
   end

   exc_fault_arbiter arb_i (
      .req      (req),
      .is_store (mem_write),
      .fault    (any_fault),
      .grant    (grant),
      .code     (code)
   );

   assign take     = ex_valid && any_fault;
   assign mem_kill = take;
   assign wb_kill  = take;

   exc_state_regs #(
      .XLEN    (XLEN),
      .PC_STEP (PC_STEP)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .take_addr (grant[SRC_ALGN]),
      .pc        (ex_pc),
      .in_ds     (ex_in_delay_slot),
      .code      (code),
      .addr      (mem_addr),
      .redirect  (redirect),
      .epc_q     (epc_q),
      .code_q    (cause_code_q),
      .bd_q      (cause_bd_q),
      .bad_q     (badvaddr_q)
   );

   // R8: every redirect follows a cycle in which the instruction was killed
   p_kill_before_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(redirect) |-> $past(wb_kill && mem_kill));
   // R13: an invalid slot never kills
   p_invalid_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_valid |-> (!mem_kill && !wb_kill));
   // R7: saved PC is corrected for a delay slot
   p_epc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && any_fault) |=>
         (epc_q == ($past(ex_in_delay_slot) ? $past(ex_pc) - XLEN'(PC_STEP) : $past(ex_pc))));
   // R10: coprocessor fault outranks everything
   p_copu_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && cop_req && cop_num != '0) |=> (cause_code_q == CODE_COPU));
endmodule

// File: tb/exc_capture_unit_tb_top.sv
module exc_capture_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ex_valid = 1'b0;
   logic [31:0] ex_pc = '0;
   logic        ex_in_delay_slot = 1'b0;
   logic        mem_req = 1'b0;
   logic        mem_write = 1'b0;
   logic [1:0]  mem_size = '0;
   logic        mem_word_merge = 1'b0;
   logic [31:0] mem_addr = '0;
   logic        ovf_req = 1'b0;
   logic        syscall_req = 1'b0;
   logic        cop_req = 1'b0;
   logic [1:0]  cop_num = '0;
   logic        user_mode = 1'b0;
   logic        cu0_en = 1'b0;
   logic        mem_kill, wb_kill, redirect, cause_bd_q;
   logic [31:0] epc_q, badvaddr_q;
   logic [4:0]  cause_code_q;

   int n_checks = 0;
   int n_fail = 0;

   // model state
   logic [31:0] m_epc = '0;
   logic [4:0]  m_code = '0;
   logic        m_bd = 1'b0;
   logic [31:0] m_bad = '0;

   always #2 clk = ~clk;

   exc_capture_unit dut_i (
      .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_pc(ex_pc),
      .ex_in_delay_slot(ex_in_delay_slot), .mem_req(mem_req), .mem_write(mem_write),
      .mem_size(mem_size), .mem_word_merge(mem_word_merge), .mem_addr(mem_addr),
      .ovf_req(ovf_req), .syscall_req(syscall_req), .cop_req(cop_req),
      .cop_num(cop_num), .user_mode(user_mode), .cu0_en(cu0_en),
      .mem_kill(mem_kill), .wb_kill(wb_kill), .redirect(redirect),
      .epc_q(epc_q), .cause_code_q(cause_code_q), .cause_bd_q(cause_bd_q),
      .badvaddr_q(badvaddr_q)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Drives one instruction, checks kills in-cycle and state after the edge.
   task automatic run_op(input string req, input logic v, input logic [31:0] pc, input logic ds,
                         input logic mr, input logic wr, input logic [1:0] sz, input logic mg,
                         input logic [31:0] a, input logic ov, input logic sc, input logic cr,
                         input logic [1:0] cn, input logic um, input logic cu);
      logic algn, copu, flt;
      logic [4:0] c;
      @(negedge clk);
      ex_valid = v; ex_pc = pc; ex_in_delay_slot = ds; mem_req = mr; mem_write = wr;
      mem_size = sz; mem_word_merge = mg; mem_addr = a; ovf_req = ov; syscall_req = sc;
      cop_req = cr; cop_num = cn; user_mode = um; cu0_en = cu;
      algn = mr && !mg && ((sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00));
      copu = cr && (cn != 2'd0 || (um && !cu));
      flt  = v && (algn || copu || ov || sc);
      c = copu ? 5'd11 : sc ? 5'd8 : ov ? 5'd12 : wr ? 5'd5 : 5'd4;
      #1;
      chk(req, "mem_kill", {31'd0, mem_kill}, {31'd0, flt});
      chk(req, "wb_kill", {31'd0, wb_kill}, {31'd0, flt});
      if (flt) begin
         m_epc = ds ? pc - 32'd4 : pc;
         m_code = c;
         m_bd = ds;
         if (!copu && !sc && !ov) m_bad = a;
      end
      @(posedge clk); #1;
      ex_valid = 1'b0; ovf_req = 1'b0; syscall_req = 1'b0; cop_req = 1'b0; mem_req = 1'b0;
      chk(req, "redirect", {31'd0, redirect}, {31'd0, flt});
      chk(req, "epc", epc_q, m_epc);
      chk(req, "code", {27'd0, cause_code_q}, {27'd0, m_code});
      chk(req, "bd", {31'd0, cause_bd_q}, {31'd0, m_bd});
      chk(req, "badvaddr", badvaddr_q, m_bad);
   endtask

   task automatic t_reset;
      @(negedge clk); #1;
      chk("R1", "epc", epc_q, 32'd0);
      chk("R1", "code", {27'd0, cause_code_q}, 32'd0);
      chk("R1", "bd", {31'd0, cause_bd_q}, 32'd0);
      chk("R1", "bad", badvaddr_q, 32'd0);
      chk("R1", "redirect", {31'd0, redirect}, 32'd0);
   endtask

   task automatic t_align;
      run_op("R2", 1, 32'h10, 0, 1, 0, 2'd0, 0, 32'h1003, 0, 0, 0, 0, 0, 0);
      run_op("R3", 1, 32'h14, 0, 1, 0, 2'd1, 0, 32'h2002, 0, 0, 0, 0, 0, 0);
      run_op("R3", 1, 32'h18, 0, 1, 1, 2'd1, 0, 32'h2001, 0, 0, 0, 0, 0, 0);
      run_op("R5", 1, 32'h1C, 0, 1, 0, 2'd2, 0, 32'h3002, 0, 0, 0, 0, 0, 0);
      run_op("R3", 1, 32'h20, 0, 1, 1, 2'd2, 0, 32'h3001, 0, 0, 0, 0, 0, 0);
      run_op("R3", 1, 32'h24, 0, 1, 0, 2'd2, 0, 32'h3000, 0, 0, 0, 0, 0, 0);
      run_op("R4", 1, 32'h28, 0, 1, 0, 2'd2, 1, 32'h4003, 0, 0, 0, 0, 0, 0);
      run_op("R4", 1, 32'h2C, 0, 1, 1, 2'd2, 1, 32'h4001, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_delay;
      run_op("R7", 1, 32'h100, 1, 1, 0, 2'd2, 0, 32'h5001, 0, 0, 0, 0, 0, 0);
      run_op("R7", 1, 32'h0, 1, 0, 0, 2'd0, 0, 32'h0, 1, 0, 0, 0, 0, 0);
   endtask

   task automatic t_faults;
      run_op("R9", 1, 32'h200, 0, 0, 0, 2'd0, 0, 32'h9999, 1, 0, 0, 0, 0, 0);
      run_op("R9", 1, 32'h204, 0, 0, 0, 2'd0, 0, 32'h0, 0, 1, 0, 0, 0, 0);
      run_op("R10", 1, 32'h208, 0, 0, 0, 2'd0, 0, 32'h0, 0, 0, 1, 2'd0, 0, 0);
      run_op("R10", 1, 32'h20C, 0, 0, 0, 2'd0, 0, 32'h0, 0, 0, 1, 2'd0, 1, 1);
      run_op("R10", 1, 32'h210, 0, 0, 0, 2'd0, 0, 32'h0, 0, 0, 1, 2'd0, 1, 0);
      run_op("R10", 1, 32'h214, 0, 0, 0, 2'd0, 0, 32'h0, 0, 0, 1, 2'd2, 0, 1);
      run_op("R10", 1, 32'h218, 0, 0, 0, 2'd0, 0, 32'h0, 0, 0, 1, 2'd3, 0, 0);
   endtask

   task automatic t_priority;
      run_op("R6", 1, 32'h300, 0, 1, 0, 2'd2, 0, 32'h6002, 0, 0, 0, 0, 0, 0);
      run_op("R11", 1, 32'h304, 0, 1, 1, 2'd2, 0, 32'h7003, 1, 1, 1, 2'd1, 0, 0);
      run_op("R11", 1, 32'h308, 0, 1, 1, 2'd1, 0, 32'h7001, 1, 1, 0, 0, 0, 0);
      run_op("R6", 1, 32'h30C, 1, 1, 0, 2'd2, 0, 32'h7002, 1, 0, 0, 0, 0, 0);
      run_op("R11", 1, 32'h310, 0, 1, 1, 2'd2, 0, 32'h7006, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_invalid;
      run_op("R13", 0, 32'h400, 1, 1, 0, 2'd2, 0, 32'h8003, 1, 1, 1, 2'd2, 1, 0);
   endtask

   task automatic t_pulse;
      run_op("R12", 1, 32'h500, 0, 0, 0, 2'd0, 0, 32'h0, 0, 1, 0, 0, 0, 0);
      @(posedge clk); #1;
      chk("R12", "redirect drop", {31'd0, redirect}, 32'd0);
      chk("R12", "epc hold", epc_q, m_epc);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_align();
      t_delay();
      t_faults();
      t_priority();
      t_invalid();
      t_pulse();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule